// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits between the serial-bus front end of a small non-volatile memory and its storage array. While a write transaction is open it collects incoming data bytes into a sixteen-entry page buffer. The start address picks the page and the first slot. Each later byte moves to the next slot, and the slot index wraps inside the page. A per-slot valid mask records which slots have been filled. When the transaction ends with Stop, a self-timed programming window opens. During that window the block steps through the page and presents each filled slot on the array write port, skipping any slot whose address the protection logic refuses. A busy flag covers the whole window.

The front end marks a transaction opening with `txn_start`, delivers bytes with `byte_valid`, and closes the transaction with `txn_stop`. If the front end sees a repeated Start before Stop, it raises `txn_abort`, and the collected bytes are dropped. The window length is the parameter `CYCLE_CLKS`, counted in system clocks: a few milliseconds on silicon, a few dozen clocks in simulation. No input has any effect while the window runs.

Top module: `pgw_page_writer`

## Requirements
- R1: The slot index starts at the low `IDX_W` bits of `txn_addr` captured on `txn_start`. It steps by one after every accepted byte. Every write issued by the commit carries the captured upper address bits unchanged.
- R2: The slot after the last slot of a page (low bits all ones) is slot 0 of the same page. The upper address bits do not change.
- R3: If more than sixteen bytes arrive before Stop, each later byte replaces the earlier one in its wrapped slot. The commit writes each slot once, with the last value received for it.
- R4: Only slots that received a byte in the current transaction produce an array write. A partial page writes exactly its received slots.
- R5: `txn_stop` with at least one buffered byte raises `busy` in the next cycle. `busy` then stays high for exactly `CYCLE_CLKS` consecutive cycles.
- R6: While `busy` is high, `txn_start`, `byte_valid`, `txn_stop` and `txn_abort` are all ignored. Bytes sent in that time are never written, and the window length does not change.
- R7: `txn_abort` discards the buffered bytes and closes the transaction without a programming window. A later transaction writes only its own bytes.
- R8: Each `txn_start` clears the valid mask. Bytes from an earlier transaction that was never stopped are not written.
- R9: A filled slot is written only if `wr_allow` is high while that slot is presented. A refused slot does not change the length of `busy`.
- R10: Array writes happen only while `busy` is high, in ascending slot order. Slot j is presented in busy cycle j, counting the first busy cycle as 0.
- R11: After reset, `busy` and `arr_we` are low.
- R12: `txn_stop` with no buffered bytes opens no programming window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Opens a write transaction and captures `txn_addr` |
| txn_addr | input | ADDR_W | Start byte address of the transaction |
| byte_valid | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | DATA_W | Data byte |
| txn_stop | input | 1 | Stop seen: commit the buffered bytes |
| txn_abort | input | 1 | Start seen before Stop: drop the buffer |
| wr_allow | input | 1 | Protection verdict for the address on `arr_addr` |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming window in progress |

## Verification
On every cycle, the bound checker enforces these properties: writes happen only inside the window and only when allowed, adjacent writes step up by one slot, the page bits stay fixed during the window, the window rises only after Stop, and the window lasts exactly `CYCLE_CLKS` cycles. The directed scenarios are needed for the buffer contents themselves. They show in-page wrap, overwrite on overflow, which slots a partial page writes, that an abort or a restarted transaction discards bytes, and that bytes sent during the window never reach the array.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_PROG = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pgw_fill.sv
module pgw_fill #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4,
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          open_req,
    input  logic [PAGE_W+IDX_W-1:0]       open_addr,
    input  logic                          byte_valid,
    input  logic [DATA_W-1:0]             byte_data,
    input  logic                          close_req,
    input  logic                          abort_req,
    input  logic                          flush,
    output logic [PAGE_W-1:0]             page,
    output logic [SLOTS-1:0]              mask,
    output logic [SLOTS-1:0][DATA_W-1:0]  data
);

    typedef struct packed {
        logic                         open;
        logic [PAGE_W-1:0]            page;
        logic [IDX_W-1:0]             idx;
        logic [SLOTS-1:0]             mask;
        logic [SLOTS-1:0][DATA_W-1:0] data;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d = fill_q;
        if (flush) begin
            fill_d.mask = '0;
        end else if (accept) begin
            if (abort_req) begin
                fill_d.open = 1'b0;
                fill_d.mask = '0;
            end else if (close_req) begin
                fill_d.open = 1'b0;
            end else if (open_req) begin
                fill_d.open = 1'b1;
                fill_d.page = open_addr[PAGE_W+IDX_W-1:IDX_W];
                fill_d.idx  = open_addr[IDX_W-1:0];
                fill_d.mask = '0;
            end else if (byte_valid && fill_q.open) begin
                fill_d.data[fill_q.idx] = byte_data;
                fill_d.mask[fill_q.idx] = 1'b1;
                fill_d.idx              = fill_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_d;
        end
    end

    assign page = fill_q.page;
    assign mask = fill_q.mask;
    assign data = fill_q.data;

endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int CYCLE_CLKS = 500000,
    parameter int CNT_W      = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic             busy,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (launch) begin
                    seq_d.st  = SEQ_PROG;
                    seq_d.cnt = '0;
                end
            end
            SEQ_PROG: begin
                if (seq_q.cnt == LAST_CNT) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy  = (seq_q.st == SEQ_PROG);
    assign count = seq_q.cnt;
    assign last  = busy && (seq_q.cnt == LAST_CNT);

endmodule

// File: rtl/pgw_commit.sv
module pgw_commit #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4,
    parameter int CNT_W  = 19,
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic                          busy,
    input  logic [CNT_W-1:0]              count,
    input  logic [PAGE_W-1:0]             page,
    input  logic [SLOTS-1:0]              mask,
    input  logic [SLOTS-1:0][DATA_W-1:0]  data,
    input  logic                          wr_allow,
    output logic                          arr_we,
    output logic [PAGE_W+IDX_W-1:0]       arr_addr,
    output logic [DATA_W-1:0]             arr_wdata
);

    logic [IDX_W-1:0] slot;
    logic             in_window;

    always_comb begin
        slot      = count[IDX_W-1:0];
        in_window = busy && ((count >> IDX_W) == '0);
        arr_addr  = {page, slot};
        arr_wdata = data[slot];
        arr_we    = in_window && mask[slot] && wr_allow;
    end

endmodule

// File: rtl/pgw_page_writer.sv
module pgw_page_writer #(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 4,
    parameter int DATA_W     = 8,
    parameter int CYCLE_CLKS = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              txn_stop,
    input  logic              txn_abort,
    input  logic              wr_allow,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);

    localparam int PAGE_W  = ADDR_W - IDX_W;
    localparam int SLOTS   = 1 << IDX_W;
    localparam int CLOG_W  = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
    localparam int CNT_W   = (CLOG_W > IDX_W) ? CLOG_W : IDX_W + 1;

    logic [PAGE_W-1:0]            page;
    logic [SLOTS-1:0]             mask;
    logic [SLOTS-1:0][DATA_W-1:0] data;
    logic [CNT_W-1:0]             count;
    logic                         last;
    logic                         launch;

    assign launch = txn_stop && !txn_abort && !busy && (|mask);

    pgw_fill #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (!busy),
        .open_req   (txn_start),
        .open_addr  (txn_addr),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .close_req  (txn_stop),
        .abort_req  (txn_abort),
        .flush      (last),
        .page       (page),
        .mask       (mask),
        .data       (data)
    );

    pgw_seq #(
        .CYCLE_CLKS (CYCLE_CLKS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .count  (count),
        .last   (last)
    );

    pgw_commit #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W),
        .CNT_W  (CNT_W)
    ) u_commit (
        .busy      (busy),
        .count     (count),
        .page      (page),
        .mask      (mask),
        .data      (data),
        .wr_allow  (wr_allow),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata)
    );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
    parameter int ADDR_W     = 8,
    parameter int IDX_W      = 4,
    parameter int CYCLE_CLKS = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txn_stop,
    input logic              wr_allow,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              busy
);

    localparam int RUN_W = $clog2(CYCLE_CLKS + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assert_we_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_we_allowed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wr_allow);

    assert_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[IDX_W-1:0] == IDX_W'($past(arr_addr[IDX_W-1:0]) + 1'b1)));

    assert_page_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:IDX_W]));

    assert_rise_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(txn_stop));

    assert_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RUN_W'(CYCLE_CLKS)));

    assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RUN_W'(CYCLE_CLKS)));

endmodule

bind pgw_page_writer pgw_checker #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .CYCLE_CLKS (CYCLE_CLKS)
) u_pgw_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txn_stop (txn_stop),
    .wr_allow (wr_allow),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .busy     (busy)
);

// File: tb/tb_pgw_page_writer.sv
module tb_pgw_page_writer;

    localparam int CLK_PERIOD = 10;
    localparam int CYC        = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic [7:0] txn_addr = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       txn_stop = 1'b0;
    logic       txn_abort = 1'b0;
    logic       wr_allow;
    logic       arr_we;
    logic [7:0] arr_addr;
    logic [7:0] arr_wdata;
    logic       busy;
    logic       prot_odd = 1'b0;

    int checks = 0;
    int errs   = 0;

    int         wr_cnt [256];
    logic [7:0] wr_val [256];
    int wr_total, busy_len, busy_rises, slot_err, stray_we;
    bit prev_busy = 1'b0;

    assign wr_allow = !(prot_odd && arr_addr[0]);

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_page_writer #(
        .ADDR_W(8), .IDX_W(4), .DATA_W(8), .CYCLE_CLKS(CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_addr(txn_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .txn_stop(txn_stop),
        .txn_abort(txn_abort), .wr_allow(wr_allow), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                if (arr_we) begin
                    wr_cnt[arr_addr] = wr_cnt[arr_addr] + 1;
                    wr_val[arr_addr] = arr_wdata;
                    wr_total = wr_total + 1;
                    if (busy_len != int'(arr_addr[3:0])) slot_err = slot_err + 1;
                end
                busy_len = busy_len + 1;
            end else if (arr_we) begin
                stray_we = stray_we + 1;
            end
            if (busy && !prev_busy) busy_rises = busy_rises + 1;
            prev_busy = busy;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 256; i++) begin
            wr_cnt[i] = 0;
            wr_val[i] = '0;
        end
        wr_total = 0; busy_len = 0; busy_rises = 0; slot_err = 0; stray_we = 0;
    endtask

    task automatic do_start(input logic [7:0] a);
        txn_start = 1'b1; txn_addr = a;
        @(posedge clk); #1 txn_start = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        byte_valid = 1'b1; byte_data = d;
        @(posedge clk); #1 byte_valid = 1'b0;
    endtask

    task automatic do_stop();
        txn_stop = 1'b1;
        @(posedge clk); #1 txn_stop = 1'b0;
    endtask

    task automatic do_abort();
        txn_abort = 1'b1;
        @(posedge clk); #1 txn_abort = 1'b0;
    endtask

    task automatic settle();
        repeat (CYC + 4) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 busy after reset", busy, 0);
        chk("R11 arr_we after reset", arr_we, 0);
    endtask

    task automatic t_single();
        clear_log();
        do_start(8'h35); do_byte(8'hA7);
        do_stop();
        @(negedge clk);
        chk("R5 busy one cycle after stop", busy, 1);
        settle();
        chk("R1 byte at start address", wr_cnt[8'h35], 1);
        chk("R1 data at start address", wr_val[8'h35], 8'hA7);
        chk("R4 single byte total writes", wr_total, 1);
        chk("R5 window length", busy_len, CYC);
        chk("R10 slot timing", slot_err, 0);
        chk("R10 no write outside window", stray_we, 0);
    endtask

    task automatic t_wrap();
        clear_log();
        do_start(8'h5E);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        do_stop(); settle();
        chk("R2 slot E", wr_val[8'h5E], 8'h11);
        chk("R2 slot F", wr_val[8'h5F], 8'h22);
        chk("R2 wrapped to slot 0 of page", wr_val[8'h50], 8'h33);
        chk("R2 no write to next page", wr_cnt[8'h60], 0);
        chk("R4 partial page write count", wr_total, 3);
    endtask

    task automatic t_overflow();
        int bad;
        clear_log();
        do_start(8'h20);
        for (int i = 1; i <= 20; i++) do_byte(8'(i));
        do_stop(); settle();
        chk("R3 total writes on overflow", wr_total, 16);
        bad = 0;
        for (int s = 0; s < 16; s++) begin
            int exp_v = (s < 4) ? s + 17 : s + 1;
            if (wr_cnt[8'h20 + s] != 1 || int'(wr_val[8'h20 + s]) != exp_v) bad++;
        end
        chk("R3 slots hold last bytes", bad, 0);
        chk("R3 slot 0 overwritten", wr_val[8'h20], 17);
    endtask

    task automatic t_abort();
        clear_log();
        do_start(8'h70); do_byte(8'hAA); do_byte(8'hBB);
        do_abort(); do_stop(); settle();
        chk("R7 no window after abort", busy_rises, 0);
        chk("R7 no writes after abort", wr_total, 0);
        do_start(8'h71); do_byte(8'hCC); do_stop(); settle();
        chk("R7 later txn writes own byte", wr_val[8'h71], 8'hCC);
        chk("R7 later txn only one write", wr_total, 1);
    endtask

    task automatic t_restart();
        clear_log();
        do_start(8'h10); do_byte(8'h55);
        do_start(8'h20); do_byte(8'h66);
        do_stop(); settle();
        chk("R8 old byte not written", wr_cnt[8'h10], 0);
        chk("R8 new byte written", wr_val[8'h20], 8'h66);
        chk("R8 total writes", wr_total, 1);
    endtask

    task automatic t_ignore_busy();
        clear_log();
        do_start(8'h00); do_byte(8'h11); do_stop();
        repeat (3) @(posedge clk); #1;
        do_start(8'h90); do_byte(8'h22); do_stop(); do_abort();
        settle();
        chk("R6 byte during window not written", wr_cnt[8'h90], 0);
        chk("R6 original byte written", wr_val[8'h00], 8'h11);
        chk("R6 window length unchanged", busy_len, CYC);
        chk("R6 only one window", busy_rises, 1);
        do_stop(); settle();
        chk("R6 no window from bytes sent while busy", busy_rises, 1);
    endtask

    task automatic t_protect();
        clear_log();
        prot_odd = 1'b1;
        do_start(8'hA0);
        for (int i = 0; i < 4; i++) do_byte(8'(8'hE0 + i));
        do_stop(); settle();
        prot_odd = 1'b0;
        chk("R9 allowed slot 0 written", wr_val[8'hA0], 8'hE0);
        chk("R9 allowed slot 2 written", wr_val[8'hA2], 8'hE2);
        chk("R9 refused slot 1 skipped", wr_cnt[8'hA1], 0);
        chk("R9 refused slot 3 skipped", wr_cnt[8'hA3], 0);
        chk("R9 window length with refusals", busy_len, CYC);
    endtask

    task automatic t_empty_stop();
        clear_log();
        do_start(8'h40); do_stop(); settle();
        chk("R12 no window on empty stop", busy_rises, 0);
        chk("R12 no writes on empty stop", wr_total, 0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        clear_log();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        @(posedge clk); #1;
        t_single();
        t_wrap();
        t_overflow();
        t_abort();
        t_restart();
        t_ignore_busy();
        t_protect();
        t_empty_stop();
        finish_run();
    end

endmodule